// File: doc/BRIEF.md
# Second-Stage Translation Accessed/Dirty Flag Updater

This block sits next to a four-level second-stage page walker. When a walk completes, the walker pulses `start` and presents the captured 64-bit entry of every level, the physical address of each entry, the level at which the walk ended (the leaf), and the kind of access that caused the walk. The block works out which entries need their accessed or dirty flag raised. For each such entry it sends one 8-byte write-back over a valid/ready memory write port. The write-backs go from the top level down, and when they are all finished the block pulses `done`.

A single enable input controls the whole feature. While it is low, no entry changes and nothing is written. While it is high, a walk made on behalf of a guest page-table access that carries a valid guest linear address is treated as a write. That access therefore also marks its leaf dirty. The updated entries stay on `ent_out` from the cycle after `start` until the next accepted start, so the walker can refresh its cached copies.

Top module: `adu_flag_updater`

## Requirements
- R1: Bit 8 of an entry is the accessed flag and bit 9 is the dirty flag. Each level above the leaf (up to level 4) whose bit 8 is clear gets one write-back whose data is the entry with bit 8 set. Each write-back goes to that entry's address.
- R2: The leaf entry gets a write-back when bit 8 is clear, or when the access counts as a write and bit 9 is clear. Its data always has bit 8 set. Bit 9 is set only for a write.
- R3: An entry whose required flags are already set produces no write-back. Levels below the leaf are never written.
- R4: Write-backs are issued from the highest level to the lowest, one at a time. The next one starts only after `wr_ready` accepts the current one. While a write-back waits for `wr_ready`, its `wr_valid`, address and data hold steady.
- R5: `acc_kind` is encoded as 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 read-modify-write. A code with bit 0 set counts as a write for the dirty flag.
- R6: When `feat_en`, `pt_walk` and `gla_valid` are all high, the access counts as a write whatever `acc_kind` says. If `gla_valid` is low, no promotion takes place.
- R7: When `feat_en` is low at start, no write-back is issued, `ent_out` equals the input entries, and `done` pulses in the next cycle.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last write-back is accepted, or the one after `start` if nothing needs writing. `done` is never high together with `wr_valid`.
- R9: From the cycle after an accepted `start`, `ent_out` shows every entry with the flags this walk sets. Level n sits in bits [64n-1 : 64n-64].
- R10: A `start` pulse that arrives while write-backs are still pending is ignored.
- R11: A leaf at level 4 means only the leaf check is made, and at most one write-back follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Enables flag updates and write promotion |
| start | input | 1 | One-cycle pulse: walk results are valid |
| leaf_lvl | input | 3 | Level at which the walk ended, 1 to 4 |
| acc_kind | input | 2 | Access kind (read, write, execute, read-modify-write) |
| pt_walk | input | 1 | Walk serves a guest page-table access |
| gla_valid | input | 1 | Guest linear address is valid |
| ent_in | input | 256 | Captured entries, level n at bits [64n-1:64n-64] |
| addr_in | input | 192 | Entry physical addresses, 48 bits per level, same order |
| wr_valid | output | 1 | Write-back request valid |
| wr_ready | input | 1 | Memory accepts the write-back |
| wr_addr | output | 48 | Write-back address |
| wr_data | output | 64 | Write-back 8-byte data |
| done | output | 1 | One-cycle completion pulse |
| ent_out | output | 256 | Updated entries |

## Verification
The assertions assume that `start` arrives only as a single-cycle pulse and that `leaf_lvl` stays between 1 and 4. They also assume that `wr_ready` may be held low for any number of cycles. The bench respects these assumptions: it drives every input on the falling edge, raises `start` for one cycle only, and uses leaf levels 1 through 4 only. It holds `wr_ready` low for a chosen number of stall cycles before each acceptance, and sends an extra `start` pulse during one of those stalls.

// File: rtl/adu_pkg.sv
package adu_pkg;
  localparam int ENT_W = 64;
  localparam int A_BIT = 8;
  localparam int D_BIT = 9;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RMW   = 2'b11
  } acc_kind_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_SEND = 1'b1
  } sq_state_e;
endpackage

// File: rtl/adu_access_class.sv
module adu_access_class
  import adu_pkg::*;
(
  input  logic       feat_en,
  input  logic [1:0] acc_kind,
  input  logic       pt_walk,
  input  logic       gla_valid,
  output logic       is_write
);
  logic native_wr;
  logic promoted;

  always_comb begin
    // write and read-modify-write both carry bit 0
    native_wr = acc_kind[0];
    promoted  = feat_en && pt_walk && gla_valid;
    is_write  = native_wr || promoted;
  end
endmodule

// File: rtl/adu_level_eval.sv
module adu_level_eval
  import adu_pkg::*;
#(
  parameter int LVL   = 1,
  parameter int LVL_W = 3
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] leaf,
  input  logic             is_write,
  input  logic             feat_en,
  output logic             need,
  output logic [ENT_W-1:0] upd
);
  localparam logic [LVL_W-1:0] MY_LVL = LVL_W'(LVL);

  logic above_leaf;
  logic at_leaf;
  logic need_acc;
  logic need_dirty;
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    above_leaf = MY_LVL > leaf;
    at_leaf    = MY_LVL == leaf;
    need_acc   = (above_leaf || at_leaf) && !entry[A_BIT];
    need_dirty = at_leaf && is_write && !entry[D_BIT];
    need       = feat_en && (need_acc || need_dirty);
    set_mask   = '0;
    set_mask[A_BIT] = 1'b1;
    set_mask[D_BIT] = at_leaf && is_write;
    upd        = need ? (entry | set_mask) : entry;
  end
endmodule

// File: rtl/adu_top_pick.sv
module adu_top_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     mask,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) idx = IDX_W'(i);
    end
    any = |mask;
  end
endmodule

// File: rtl/adu_wb_seq.sv
module adu_wb_seq
  import adu_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int ADDR_W = 48,
  localparam int IDX_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [LEVELS-1:0]         need_mask,
  input  logic [LEVELS*ENT_W-1:0]   new_ent,
  input  logic [LEVELS*ADDR_W-1:0]  addr_in,
  input  logic                      wr_ready,
  output logic                      wr_valid,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [ENT_W-1:0]          wr_data,
  output logic                      done,
  output logic [LEVELS*ENT_W-1:0]   ent_out
);
  sq_state_e          state;
  logic [LEVELS-1:0]  pending;
  logic [IDX_W-1:0]   cur;
  logic [ENT_W-1:0]   ent_q  [LEVELS];
  logic [ADDR_W-1:0]  addr_q [LEVELS];

  logic [LEVELS-1:0]  pending_after;
  logic [LEVELS-1:0]  pick_src;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;

  always_comb begin
    pending_after = pending & ~(LEVELS'(1) << cur);
    pick_src      = (state == SQ_IDLE) ? need_mask : pending_after;
  end

  adu_top_pick #(.N(LEVELS), .IDX_W(IDX_W)) u_pick (
    .mask (pick_src),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      pending  <= '0;
      cur      <= '0;
      wr_valid <= 1'b0;
      done     <= 1'b0;
      for (int i = 0; i < LEVELS; i++) begin
        ent_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            for (int i = 0; i < LEVELS; i++) begin
              ent_q[i]  <= new_ent[i*ENT_W +: ENT_W];
              addr_q[i] <= addr_in[i*ADDR_W +: ADDR_W];
            end
            pending <= need_mask;
            if (pick_any) begin
              cur      <= pick_idx;
              wr_valid <= 1'b1;
              state    <= SQ_SEND;
            end else begin
              done <= 1'b1;
            end
          end
        end
        SQ_SEND: begin
          if (wr_ready) begin
            pending <= pending_after;
            if (pick_any) begin
              cur <= pick_idx;
            end else begin
              wr_valid <= 1'b0;
              done     <= 1'b1;
              state    <= SQ_IDLE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_addr = addr_q[cur];
    wr_data = ent_q[cur];
  end

  for (genvar g = 0; g < LEVELS; g++) begin : g_out
    assign ent_out[g*ENT_W +: ENT_W] = ent_q[g];
  end
endmodule

// File: rtl/adu_flag_updater.sv
module adu_flag_updater
  import adu_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int ADDR_W = 48,
  localparam int LVL_W = $clog2(LEVELS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     feat_en,
  input  logic                     start,
  input  logic [LVL_W-1:0]         leaf_lvl,
  input  logic [1:0]               acc_kind,
  input  logic                     pt_walk,
  input  logic                     gla_valid,
  input  logic [LEVELS*ENT_W-1:0]  ent_in,
  input  logic [LEVELS*ADDR_W-1:0] addr_in,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [ENT_W-1:0]         wr_data,
  output logic                     done,
  output logic [LEVELS*ENT_W-1:0]  ent_out
);
  logic                    is_write;
  logic [LEVELS-1:0]       need_mask;
  logic [LEVELS*ENT_W-1:0] new_ent;

  adu_access_class u_class (
    .feat_en   (feat_en),
    .acc_kind  (acc_kind),
    .pt_walk   (pt_walk),
    .gla_valid (gla_valid),
    .is_write  (is_write)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    adu_level_eval #(.LVL(g + 1), .LVL_W(LVL_W)) u_eval (
      .entry    (ent_in[g*ENT_W +: ENT_W]),
      .leaf     (leaf_lvl),
      .is_write (is_write),
      .feat_en  (feat_en),
      .need     (need_mask[g]),
      .upd      (new_ent[g*ENT_W +: ENT_W])
    );
  end

  adu_wb_seq #(.LEVELS(LEVELS), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .need_mask (need_mask),
    .new_ent   (new_ent),
    .addr_in   (addr_in),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done),
    .ent_out   (ent_out)
  );
endmodule

// File: rtl/adu_flag_updater_chk.sv
module adu_flag_updater_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              feat_en,
  input logic              start,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [63:0]       wr_data,
  input logic              done
);
  p_hold_stall_r4: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_acc_flag_set_r1: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_data[8]);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid);

  p_off_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    start && !feat_en && !wr_valid |=> !wr_valid && done);

  p_stall_no_done_r10: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> !done);
endmodule

bind adu_flag_updater adu_flag_updater_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .feat_en  (feat_en),
  .start    (start),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .done     (done)
);

// File: tb/adu_flag_updater_test.sv
module adu_flag_updater_test;
  localparam int CLK_PERIOD = 10;
  localparam int LV = 4;
  localparam int AW = 48;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            feat_en = 1'b0;
  logic            start = 1'b0;
  logic [2:0]      leaf_lvl = 3'd1;
  logic [1:0]      acc_kind = 2'b00;
  logic            pt_walk = 1'b0;
  logic            gla_valid = 1'b0;
  logic [LV*64-1:0] ent_in = '0;
  logic [LV*AW-1:0] addr_in = '0;
  logic            wr_valid;
  logic            wr_ready = 1'b0;
  logic [AW-1:0]   wr_addr;
  logic [63:0]     wr_data;
  logic            done;
  logic [LV*64-1:0] ent_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adu_flag_updater uut (
    .clk(clk), .rst(rst), .feat_en(feat_en), .start(start),
    .leaf_lvl(leaf_lvl), .acc_kind(acc_kind), .pt_walk(pt_walk),
    .gla_valid(gla_valid), .ent_in(ent_in), .addr_in(addr_in),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .ent_out(ent_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Spec model: expected write-backs (top-down) and expected updated entries.
  task automatic run_case(input string req, input logic [63:0] e [LV],
                          input int leaf, input logic [1:0] kind,
                          input logic walk, input logic gla, input logic en,
                          input int stall, input bit poke);
    logic [63:0] exp_out [LV];
    logic [63:0] exp_data [LV];
    logic [AW-1:0] exp_addr [LV];
    int n = 0;
    bit w;
    w = kind[0] || (en && walk && gla);
    for (int l = LV; l >= 1; l--) begin
      logic [63:0] v;
      bit need;
      v = e[l-1];
      need = 0;
      if (l > leaf) need = !v[8];
      else if (l == leaf) need = !v[8] || (w && !v[9]);
      if (!en) need = 0;
      if (need) begin
        v[8] = 1'b1;
        if (l == leaf && w) v[9] = 1'b1;
        exp_addr[n] = AW'(48'h0000_8000_0000 + 48'(l) * 48'h1008);
        exp_data[n] = v;
        n++;
      end
      exp_out[l-1] = v;
    end
    @(negedge clk);
    for (int l = 1; l <= LV; l++) begin
      ent_in[(l-1)*64 +: 64] = e[l-1];
      addr_in[(l-1)*AW +: AW] = AW'(48'h0000_8000_0000 + 48'(l) * 48'h1008);
    end
    leaf_lvl = 3'(leaf); acc_kind = kind; pt_walk = walk;
    gla_valid = gla; feat_en = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      for (int s = 0; s < stall; s++) begin
        chk(wr_valid && wr_addr == exp_addr[k] && wr_data == exp_data[k] && !done,
            req, "stalled write-back", wr_data, exp_data[k]);
        if (poke && k == 0 && s == 0) begin
          ent_in = '0; leaf_lvl = 3'd1; acc_kind = 2'b01; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
      start = 1'b0;
      chk(wr_valid && !done, req, "write-back valid", 64'(wr_valid), 64'd1);
      chk(wr_addr == exp_addr[k], req, "write-back address", 64'(wr_addr), 64'(exp_addr[k]));
      chk(wr_data == exp_data[k], req, "write-back data", wr_data, exp_data[k]);
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
    end
    chk(done == 1'b1 && !wr_valid, "R8", {req, " done pulse"}, 64'(done), 64'd1);
    for (int l = 1; l <= LV; l++)
      chk(ent_out[(l-1)*64 +: 64] == exp_out[l-1], "R9", {req, " updated entry"},
          ent_out[(l-1)*64 +: 64], exp_out[l-1]);
    @(negedge clk);
    chk(!done && !wr_valid, req, "quiet after done", {62'd0, done, wr_valid}, 64'd0);
  endtask

  localparam logic [63:0] BASE = 64'h0000_0ABC_DE00_0007;
  localparam logic [63:0] AF = 64'h100;
  localparam logic [63:0] DF = 64'h200;

  task automatic t_reset();
    chk(!wr_valid && !done, "R8", "reset outputs idle", {62'd0, done, wr_valid}, 64'd0);
  endtask

  task automatic t_clear_read_leaf1();   // R1 R2 R4
    logic [63:0] e [LV] = '{BASE, BASE ^ 64'h10000, BASE ^ 64'h20000, BASE ^ 64'h30000};
    run_case("R1", e, 1, 2'b00, 0, 0, 1, 0, 0);
  endtask

  task automatic t_clear_write_leaf1();  // R2 R5 write code 01
    logic [63:0] e [LV] = '{BASE, BASE, BASE, BASE};
    run_case("R2", e, 1, 2'b01, 0, 0, 1, 0, 0);
  endtask

  task automatic t_all_set();            // R3 no write-back
    logic [63:0] e [LV] = '{BASE | AF, BASE | AF, BASE | AF, BASE | AF};
    run_case("R3", e, 1, 2'b00, 0, 0, 1, 0, 0);
  endtask

  task automatic t_mixed_leaf2();        // R3 level 1 untouched, only dirty at leaf
    logic [63:0] e [LV] = '{BASE, BASE | AF, BASE, BASE | AF};
    run_case("R3", e, 2, 2'b01, 0, 0, 1, 0, 0);
  endtask

  task automatic t_leaf4_rmw();          // R11 R5 rmw code 11
    logic [63:0] e [LV] = '{BASE, BASE, BASE, BASE};
    run_case("R11", e, 4, 2'b11, 0, 0, 1, 0, 0);
  endtask

  task automatic t_exec_leaf3();         // R5 execute code 10 is not a write
    logic [63:0] e [LV] = '{BASE, BASE, BASE | AF, BASE};
    run_case("R5", e, 3, 2'b10, 0, 0, 1, 0, 0);
  endtask

  task automatic t_promote();            // R6
    logic [63:0] e [LV] = '{BASE | AF, BASE | AF, BASE | AF, BASE | AF};
    run_case("R6", e, 1, 2'b00, 1, 1, 1, 0, 0);
    run_case("R6", e, 1, 2'b00, 1, 0, 1, 0, 0);
  endtask

  task automatic t_disabled();           // R7
    logic [63:0] e [LV] = '{BASE, BASE, BASE, BASE};
    run_case("R7", e, 1, 2'b01, 1, 1, 0, 0, 0);
  endtask

  task automatic t_stall_poke();         // R4 R10
    logic [63:0] e [LV] = '{BASE | AF | DF, BASE, BASE | AF, BASE};
    run_case("R4", e, 1, 2'b00, 0, 0, 1, 2, 0);
    run_case("R10", e, 2, 2'b01, 0, 0, 1, 3, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_clear_read_leaf1();
    t_clear_write_leaf1();
    t_all_set();
    t_mixed_leaf2();
    t_leaf4_rmw();
    t_exec_leaf3();
    t_promote();
    t_disabled();
    t_stall_poke();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule